// File: doc/BRIEF.md
# Embedded-Clock Frame Lock Detector

This block finds frame alignment in a serial bit stream whose clock is carried inside the data. Every frame is 20 bit slots long. It has a start bit of 1, then 18 data bits sent most significant first, then a stop bit of 0. The boundary from a stop bit to the next start bit is therefore always a 0-to-1 edge. The block watches windows of 20 strobed bits and notes every slot that carries a 0-to-1 edge. It declares lock only when one single slot has carried the only edge of its window for several windows in a row.

Data that places a low bit next to a high bit creates extra candidate edges. While such a pattern repeats, no window has a single candidate, so the lock output stays inactive. A sync word of nine ones followed by nine zeros leaves exactly one edge per frame, so the block can acquire lock from it at any phase. Once locked, the block checks for the edge at the locked slot on every frame. It tolerates a single missing edge and drops lock after two misses in a row. While locked, it presents each received data word with a one-cycle valid pulse.

Top module: `frame_lock_detect`

## Requirements
- R1: A synchronous active-high reset drives lock_n to 1 and rx_valid to 0, clears all candidate history and the strobe slot counter, and returns the block to searching.
- R2: Slots are counted 0 to 19 from reset, advancing on each strobe. Windows are the groups of 20 strobes that end on slot 19. An edge is a strobed 1 whose preceding strobed bit was 0, with the bit before the first strobe after reset taken as 0. Lock_n falls on the clock after the strobe that ends the fourth window in a row in which exactly one slot, the same slot each time, held an edge.
- R3: A window with zero edges or with two or more edges restarts the count of R2. A repeating pattern that gives several edges per window therefore keeps lock_n at 1.
- R4: While locked, a frame with no edge at the locked slot keeps lock_n at 0 if the previous frame did have the edge.
- R5: Two consecutive frames with no edge at the locked slot drive lock_n to 1 on the clock after the second missing strobe, and searching restarts from an empty history.
- R6: On the strobe at the locked slot, rx_data is loaded with the 18 bits received on the 18 strobes that came before the one just before it. The earliest of these bits goes into bit 17.
- R7: rx_valid pulses for one clock with each R6 load. It pulses only if the block is still locked after that strobe, and it is never 1 while lock_n is 1.
- R8: A sync stream, in which each frame carries nine ones and then nine zeros as data, gives lock within 100 strobes from any starting phase.
- R9: A clock without bit_stb changes no state: lock_n holds its value and rx_valid is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_stb | input | 1 | Marks ser_bit as a new serial bit this cycle |
| ser_bit | input | 1 | Serial data bit |
| rx_data | output | 18 | Recovered data word, bit 17 received first |
| rx_valid | output | 1 | One-cycle pulse when rx_data is loaded |
| lock_n | output | 1 | Active-low frame lock indication |

## Verification
The assertions assume that bit_stb marks each serial bit for exactly one clock. They also assume that lock can change only on a strobed clock or through reset, which is why a strobe-free clock must leave lock_n unchanged. The bench drives each bit as a single-cycle strobe. In some phases it inserts idle clocks between strobes, which exercises the hold behaviour without breaking that assumption. Reset is held for whole clocks and released on a falling edge, so the reset-guarded properties never see a half-applied reset.

// File: rtl/fld_pkg.sv
`timescale 1ns/1ps
package fld_pkg;
  localparam int unsigned DEF_DATA_W     = 18;
  localparam int unsigned DEF_ACQ_FRAMES = 4;
  localparam int unsigned DEF_MISS_LIMIT = 2;

  typedef enum logic {
    ST_SEARCH = 1'b0,
    ST_LOCKED = 1'b1
  } fld_state_e;
endpackage

// File: rtl/fld_slot_front.sv
`timescale 1ns/1ps
module fld_slot_front #(
  parameter int unsigned DATA_W  = 18,
  parameter int unsigned FRAME_W = DATA_W + 2,
  parameter int unsigned SLOT_W  = $clog2(FRAME_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_stb,
  input  logic              ser_bit,
  output logic [SLOT_W-1:0] slot,
  output logic              edge_hit,
  output logic [DATA_W-1:0] frame_data
);
  // history of the last FRAME_W-1 bits; bit 0 is the newest
  logic [FRAME_W-2:0] hist_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hist_q <= '0;
      slot   <= '0;
    end else if (bit_stb) begin
      hist_q <= {hist_q[FRAME_W-3:0], ser_bit};
      slot   <= (slot == SLOT_W'(FRAME_W - 1)) ? '0 : slot + 1'b1;
    end
  end

  assign edge_hit   = ser_bit & ~hist_q[0];
  assign frame_data = hist_q[FRAME_W-2:1];
endmodule

// File: rtl/fld_acquire.sv
`timescale 1ns/1ps
module fld_acquire #(
  parameter int unsigned FRAME_W    = 20,
  parameter int unsigned ACQ_FRAMES = 4,
  parameter int unsigned SLOT_W     = $clog2(FRAME_W),
  parameter int unsigned CNT_W      = $clog2(ACQ_FRAMES + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_stb,
  input  logic              searching,
  input  logic [SLOT_W-1:0] slot,
  input  logic              edge_hit,
  output logic              acq_fire,
  output logic [SLOT_W-1:0] acq_slot
);
  logic [FRAME_W-1:0] mask_q, mask_d;
  logic [CNT_W-1:0]   streak_q, streak_next;
  logic [SLOT_W-1:0]  cand_q, hit_idx;
  logic               single, window_end;

  always_comb begin
    mask_d       = mask_q;
    mask_d[slot] = mask_q[slot] | edge_hit;
    single       = ($countones(mask_d) == 1);
    hit_idx      = '0;
    for (int i = 0; i < FRAME_W; i++) begin
      if (mask_d[i]) hit_idx = SLOT_W'(i);
    end
    streak_next = (streak_q != '0 && hit_idx == cand_q) ? streak_q + 1'b1 : CNT_W'(1);
    window_end  = bit_stb && searching && (slot == SLOT_W'(FRAME_W - 1));
    acq_fire    = window_end && single && (streak_next == CNT_W'(ACQ_FRAMES));
    acq_slot    = hit_idx;
  end

  always_ff @(posedge clk) begin
    if (rst || !searching) begin
      mask_q   <= '0;
      streak_q <= '0;
      cand_q   <= '0;
    end else if (bit_stb) begin
      if (window_end) begin
        mask_q <= '0;
        if (single) begin
          streak_q <= acq_fire ? '0 : streak_next;
          cand_q   <= hit_idx;
        end else begin
          streak_q <= '0;
        end
      end else begin
        mask_q <= mask_d;
      end
    end
  end
endmodule

// File: rtl/fld_track.sv
`timescale 1ns/1ps
module fld_track
  import fld_pkg::*;
#(
  parameter int unsigned DATA_W     = 18,
  parameter int unsigned MISS_LIMIT = 2,
  parameter int unsigned SLOT_W     = 5,
  parameter int unsigned MISS_W     = $clog2(MISS_LIMIT + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_stb,
  input  logic [SLOT_W-1:0] slot,
  input  logic              edge_hit,
  input  logic [DATA_W-1:0] frame_data,
  input  logic              acq_fire,
  input  logic [SLOT_W-1:0] acq_slot,
  output logic              searching,
  output logic              lock_n,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid
);
  fld_state_e        state_q;
  logic [SLOT_W-1:0] lock_slot_q;
  logic [MISS_W-1:0] miss_q;
  logic              at_slot, last_miss;

  assign at_slot   = (state_q == ST_LOCKED) && bit_stb && (slot == lock_slot_q);
  assign last_miss = !edge_hit && (miss_q == MISS_W'(MISS_LIMIT - 1));
  assign searching = (state_q == ST_SEARCH);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_SEARCH;
      lock_slot_q <= '0;
      miss_q      <= '0;
      lock_n      <= 1'b1;
      rx_valid    <= 1'b0;
      rx_data     <= '0;
    end else begin
      rx_valid <= 1'b0;
      case (state_q)
        ST_SEARCH: begin
          if (bit_stb && acq_fire) begin
            state_q     <= ST_LOCKED;
            lock_slot_q <= acq_slot;
            miss_q      <= '0;
            lock_n      <= 1'b0;
          end
        end
        default: begin
          if (at_slot) begin
            if (edge_hit) begin
              miss_q <= '0;
            end else if (last_miss) begin
              state_q <= ST_SEARCH;
              miss_q  <= '0;
              lock_n  <= 1'b1;
            end else begin
              miss_q <= miss_q + 1'b1;
            end
            if (edge_hit || !last_miss) begin
              rx_valid <= 1'b1;
              rx_data  <= frame_data;
            end
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/frame_lock_detect.sv
`timescale 1ns/1ps
module frame_lock_detect
  import fld_pkg::*;
#(
  parameter int unsigned DATA_W     = DEF_DATA_W,
  parameter int unsigned ACQ_FRAMES = DEF_ACQ_FRAMES,
  parameter int unsigned MISS_LIMIT = DEF_MISS_LIMIT
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_stb,
  input  logic              ser_bit,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              lock_n
);
  localparam int unsigned FRAME_W = DATA_W + 2;
  localparam int unsigned SLOT_W  = $clog2(FRAME_W);

  logic [SLOT_W-1:0] slot, acq_slot;
  logic              edge_hit, acq_fire, searching;
  logic [DATA_W-1:0] frame_data;

  fld_slot_front #(.DATA_W(DATA_W), .FRAME_W(FRAME_W), .SLOT_W(SLOT_W)) u_front (
    .clk(clk), .rst(rst), .bit_stb(bit_stb), .ser_bit(ser_bit),
    .slot(slot), .edge_hit(edge_hit), .frame_data(frame_data)
  );

  fld_acquire #(.FRAME_W(FRAME_W), .ACQ_FRAMES(ACQ_FRAMES), .SLOT_W(SLOT_W)) u_acq (
    .clk(clk), .rst(rst), .bit_stb(bit_stb), .searching(searching),
    .slot(slot), .edge_hit(edge_hit), .acq_fire(acq_fire), .acq_slot(acq_slot)
  );

  fld_track #(.DATA_W(DATA_W), .MISS_LIMIT(MISS_LIMIT), .SLOT_W(SLOT_W)) u_track (
    .clk(clk), .rst(rst), .bit_stb(bit_stb), .slot(slot), .edge_hit(edge_hit),
    .frame_data(frame_data), .acq_fire(acq_fire), .acq_slot(acq_slot),
    .searching(searching), .lock_n(lock_n), .rx_data(rx_data), .rx_valid(rx_valid)
  );
endmodule

// File: rtl/fld_checker.sv
`timescale 1ns/1ps
module fld_checker #(
  parameter int unsigned DATA_W = 18
) (
  input logic              clk,
  input logic              rst,
  input logic              bit_stb,
  input logic              lock_n,
  input logic              rx_valid,
  input logic [DATA_W-1:0] rx_data
);
  a_r1_reset_state: assert property (@(posedge clk) rst |=> (lock_n && !rx_valid));

  a_r7_valid_needs_lock: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> !lock_n);

  a_r7_valid_one_cycle: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);

  a_r9_hold_without_strobe: assert property (@(posedge clk) disable iff (rst)
    !bit_stb |=> $stable(lock_n));

  a_r2_lock_on_strobe: assert property (@(posedge clk) disable iff (rst)
    $fell(lock_n) |-> $past(bit_stb));

  a_r5_unlock_on_strobe: assert property (@(posedge clk) disable iff (rst)
    $rose(lock_n) |-> ($past(bit_stb) || $past(rst)));

  a_r6_data_held: assert property (@(posedge clk) disable iff (rst)
    (!rx_valid && !$past(rst)) |-> $stable(rx_data));
endmodule

bind frame_lock_detect fld_checker #(.DATA_W(DATA_W)) u_fld_checker (
  .clk(clk), .rst(rst), .bit_stb(bit_stb), .lock_n(lock_n),
  .rx_valid(rx_valid), .rx_data(rx_data)
);

// File: tb/frame_lock_detect_bench.sv
`timescale 1ns/1ps
module frame_lock_detect_bench;
  localparam int DW = 18;
  localparam int FW = DW + 2;
  localparam logic [DW-1:0] SYNC_WORD = 18'b111111111_000000000;

  logic clk = 1'b0, rst = 1'b1, bit_stb = 1'b0, ser_bit = 1'b0;
  logic [DW-1:0] rx_data;
  logic rx_valid, lock_n;

  always #2.5 clk = ~clk;

  frame_lock_detect u_frame_lock_detect (
    .clk(clk), .rst(rst), .bit_stb(bit_stb), .ser_bit(ser_bit),
    .rx_data(rx_data), .rx_valid(rx_valid), .lock_n(lock_n)
  );

  int errors = 0, checks = 0, g_gap = 0, valid_cnt = 0, cycles = 0;
  logic [DW-1:0] got_data = '0;
  bit finished = 0;

  // behavioural reference model
  int m_slot, m_locked, m_lock_at, m_miss, m_streak, m_cand;
  int seen[FW];
  bit hist[$];
  bit exp_lock_n = 1, exp_valid = 0;
  logic [DW-1:0] exp_data = '0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_slot = 0; m_locked = 0; m_lock_at = 0; m_miss = 0; m_streak = 0; m_cand = 0;
    foreach (seen[i]) seen[i] = 0;
    hist.delete();
    for (int i = 0; i < FW - 1; i++) hist.push_back(1'b0);
    exp_lock_n = 1; exp_valid = 0;
  endtask

  task automatic model_step(input bit r, input bit s, input bit b);
    bit e;
    int cnt, idx;
    exp_valid = 0;
    if (r) begin
      model_reset();
    end else if (s) begin
      e = b && !hist[FW-2];
      if (m_locked != 0) begin
        if (m_slot == m_lock_at) begin
          if (e) begin
            m_miss = 0; exp_valid = 1;
          end else begin
            m_miss++;
            if (m_miss >= 2) begin
              m_locked = 0; m_miss = 0; exp_lock_n = 1;
            end else exp_valid = 1;
          end
          if (exp_valid) for (int i = 0; i < DW; i++) exp_data[DW-1-i] = hist[i];
        end
        foreach (seen[i]) seen[i] = 0;
        m_streak = 0;
      end else begin
        if (e) seen[m_slot] = 1;
        if (m_slot == FW - 1) begin
          cnt = 0; idx = 0;
          foreach (seen[i]) if (seen[i] != 0) begin cnt++; idx = i; end
          if (cnt == 1) begin
            if (m_streak > 0 && idx == m_cand) m_streak++;
            else m_streak = 1;
            m_cand = idx;
            if (m_streak == 4) begin
              m_locked = 1; m_lock_at = idx; m_miss = 0; m_streak = 0; exp_lock_n = 0;
            end
          end else m_streak = 0;
          foreach (seen[i]) seen[i] = 0;
        end
      end
      void'(hist.pop_front());
      hist.push_back(b);
      m_slot = (m_slot + 1) % FW;
    end
  endtask

  always @(posedge clk) begin
    model_step(rst, bit_stb, ser_bit);
    #1;
    cycles++;
    if (rx_valid) begin got_data = rx_data; valid_cnt++; end
    if (!finished) begin
      check(lock_n === exp_lock_n, "R3", "lock_n vs model", lock_n, exp_lock_n);
      check(rx_valid === exp_valid, "R7", "rx_valid vs model", rx_valid, exp_valid);
      if (exp_valid) check(rx_data === exp_data, "R6", "rx_data vs model", rx_data, exp_data);
    end
  end

  // watchdog
  always @(posedge clk) begin
    if (cycles > 150000 && !finished) begin
      finished = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected=<150000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic send_bit(input bit b);
    @(negedge clk);
    bit_stb = 1'b1; ser_bit = b;
    @(negedge clk);
    bit_stb = 1'b0;
    repeat (g_gap) @(negedge clk);
  endtask

  task automatic send_frame(input logic [DW-1:0] d, input bit good_start);
    send_bit(good_start);
    for (int i = DW - 1; i >= 0; i--) send_bit(d[i]);
    send_bit(1'b0);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; bit_stb = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    logic held;
    int vc;
    logic [FW-1:0] sync_bits;
    do_reset();
    check(lock_n === 1'b1, "R1", "lock_n after reset", lock_n, 1);
    check(rx_valid === 1'b0, "R1", "rx_valid after reset", rx_valid, 0);

    // R2: exact acquisition point on sync frames from phase 0
    for (int f = 0; f < 3; f++) send_frame(SYNC_WORD, 1'b1);
    send_bit(1'b1);
    for (int i = DW - 1; i >= 0; i--) send_bit(SYNC_WORD[i]);
    check(lock_n === 1'b1, "R2", "lock_n after 79 strobes", lock_n, 1);
    send_bit(1'b0);
    check(lock_n === 1'b0, "R2", "lock_n after 80 strobes", lock_n, 0);

    // R6/R7: data words while locked
    vc = valid_cnt;
    send_frame(18'h2B4C7, 1'b1);
    send_frame(18'h15A3E, 1'b1);
    check(got_data === 18'h2B4C7, "R6", "first data word", got_data, 18'h2B4C7);
    send_frame(SYNC_WORD, 1'b1);
    check(got_data === 18'h15A3E, "R6", "second data word", got_data, 18'h15A3E);
    check(valid_cnt - vc == 3, "R7", "valid pulses for three frames", valid_cnt - vc, 3);

    // R4: one missing edge keeps lock
    send_frame(18'h3F00F, 1'b0);
    check(lock_n === 1'b0, "R4", "lock_n after one miss", lock_n, 0);
    send_frame(18'h0F0F0, 1'b1);
    check(lock_n === 1'b0, "R4", "lock_n after recovery frame", lock_n, 0);

    // R9: gap cycles hold state
    @(negedge clk); held = lock_n;
    repeat (4) begin
      @(negedge clk);
      check(lock_n === held, "R9", "lock_n held without strobe", lock_n, held);
      check(rx_valid === 1'b0, "R9", "rx_valid without strobe", rx_valid, 0);
    end

    // R5: two misses drop lock
    send_frame(18'h12345, 1'b0);
    send_frame(18'h0ABCD, 1'b0);
    check(lock_n === 1'b1, "R5", "lock_n after two misses", lock_n, 1);

    // R3: repetitive multi-edge data never locks
    vc = valid_cnt;
    for (int f = 0; f < 12; f++) send_frame(18'h15555, 1'b1);
    check(lock_n === 1'b1, "R3", "lock_n during multi-edge pattern", lock_n, 1);
    check(valid_cnt == vc, "R7", "no valid while unlocked", valid_cnt - vc, 0);

    // pattern changes to sync: lock returns (R3)
    for (int f = 0; f < 6; f++) send_frame(SYNC_WORD, 1'b1);
    check(lock_n === 1'b0, "R3", "lock after pattern changes", lock_n, 0);

    // R1: reset while locked
    do_reset();
    check(lock_n === 1'b1, "R1", "lock_n after reset while locked", lock_n, 1);

    // R8: sync from an odd phase, with gaps between strobes
    g_gap = 2;
    sync_bits = {1'b1, SYNC_WORD, 1'b0};
    for (int i = 13; i >= 0; i--) send_bit(sync_bits[i]);
    for (int f = 0; f < 5; f++) send_frame(SYNC_WORD, 1'b1);
    check(lock_n === 1'b0, "R8", "lock from offset sync phase", lock_n, 0);
    send_frame(18'h2AAAA, 1'b1);
    send_frame(SYNC_WORD, 1'b1);
    check(got_data === 18'h2AAAA, "R6", "data word with gaps", got_data, 18'h2AAAA);
    g_gap = 0;

    repeat (3) @(negedge clk);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule